// File: doc/BRIEF.md
# Data Watchpoint Monitor

This block sits beside a processor's data port and watches each memory access for contact with one programmed window of bytes. When an access qualifies under the selected watch mode, it raises a break request for exactly one cycle, on the cycle after the access. It also sets a hit flag that stays high until software clears it. A debug controller uses the break request to halt the core. Software polls the hit flag to learn that the watch has fired since it last looked.

The window is a naturally aligned group of 1, 2 or 4 bytes inside one bus word. Three firing rules are available. Write mode fires on every store into the window, even when the stored value is unchanged. Read/write mode fires on any load or store into the window. Change-only mode fires only when a store alters at least one watched byte. To support change-only mode, the monitor compares the store data against the word's present contents, which the bus also supplies. The configuration inputs are decoded directly, so a new setting applies to the very next access.

Top module: `wp_watch`

## Requirements
- R1: `cfgSpan` selects the window size: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 gives 4 bytes. The window is the aligned group of that size that contains byte lane `cfgAddr[1:0]`, so lane k belongs to the window when k and `cfgAddr[1:0]` agree above bit `cfgSpan`.
- R2: An access touches the window only when `busWordAddr` equals `cfgAddr[31:2]` and at least one set bit of `busBe` falls on a window lane. Bit k of `busBe` selects byte lane k, which is data bits 8k+7..8k.
- R3: With `cfgMode` = 0 (write), every write (`busWr`=1) that touches the window fires, even when the written bytes equal the old bytes. Reads do not fire.
- R4: With `cfgMode` = 1 (read/write), any read (`busRd`=1) or write that touches the window fires.
- R5: With `cfgMode` = 2 (change-only), a write fires only when some lane that is both enabled and in the window holds a different value in `busWdata` than in `busOldData`. Reads never fire in this mode.
- R6: A firing access produces `breakPulse` high for exactly the one cycle after the access. Cycles without a firing access leave `breakPulse` low.
- R7: `hitFlag` rises together with `breakPulse` and stays high until a cycle with `clearHit`=1 and no firing access. If a firing access and `clearHit` arrive in the same cycle, the flag ends up set.
- R8: With `cfgEnable`=0, no access fires.
- R9: Changes to the configuration take effect for an access presented in the same cycle.
- R10: `cfgMode` = 3 is reserved and never fires.
- R11: While `rstN` is low, `breakPulse` and `hitFlag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Global watch enable |
| cfgMode | input | 2 | Watch mode: 0 write, 1 read/write, 2 change-only, 3 reserved |
| cfgSpan | input | 2 | Window size code: 1, 2 or 4 bytes |
| cfgAddr | input | 32 | Byte address of the window |
| clearHit | input | 1 | Clears the sticky hit flag |
| busWordAddr | input | 30 | Word address of the current access |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busBe | input | 4 | Byte-lane enables of the access |
| busWdata | input | 32 | Write data |
| busOldData | input | 32 | Current contents of the addressed word |
| breakPulse | output | 1 | One-cycle break request |
| hitFlag | output | 1 | Sticky hit indication |

## Verification
The hardest case to reach is a change-only store whose enabled lanes differ from memory only outside the window, while the window lanes themselves are unchanged. Uniform random data almost never produces this, so the bench builds it directly. It also biases the random addresses toward the watched word, and half the time copies the old data into the write data and then flips single bytes. Other cases that random traffic seldom hits are also built directly: a clear that lands in the same cycle as a hit, and a window move that is followed at once by an access to the new window.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_RDWR   = 2'd1,
    MODE_CHANGE = 2'd2,
    MODE_OFF    = 2'd3
  } watchMode_e;

  // Match information the datapath hands to the control.
  typedef struct packed {
    logic hitAny;   // access touches a watched lane of the watched word
    logic differs;  // some touched watched lane carries new data
    logic isRead;
    logic isWrite;
  } wpMatch_t;

  // Strobes the control hands back to the datapath.
  typedef struct packed {
    logic fire;
    logic clear;
  } wpStrobe_t;

endpackage

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int SPAN_W = $clog2(OFF_W + 1),
  localparam int WORD_W = ADDR_W - OFF_W,
  localparam int DATA_W = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SPAN_W-1:0] cfgSpan,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [WORD_W-1:0] busWordAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [BYTES-1:0]  busBe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busOldData,
  input  wpStrobe_t         strobes,
  output wpMatch_t          matchInfo,
  output logic              breakPulse,
  output logic              hitFlag
);

  logic [SPAN_W-1:0] spanLog;
  logic [OFF_W-1:0]  baseLane;
  logic [BYTES-1:0]  watchMask;
  logic [BYTES-1:0]  touchMask;
  logic [BYTES-1:0]  diffMask;
  logic              wordHit;

  // Sizes beyond one word saturate at the full word.
  always_comb begin
    spanLog  = (cfgSpan > SPAN_W'(OFF_W)) ? SPAN_W'(OFF_W) : cfgSpan;
    baseLane = cfgAddr[OFF_W-1:0];
    wordHit  = (busWordAddr == cfgAddr[ADDR_W-1:OFF_W]);
  end

  for (genvar lane = 0; lane < BYTES; lane++) begin : g_lane
    logic [OFF_W-1:0] laneIdx;
    assign laneIdx = OFF_W'(lane);
    // A lane is watched when it shares the aligned group of the base lane.
    assign watchMask[lane] = ((laneIdx >> spanLog) == (baseLane >> spanLog));
    assign touchMask[lane] = watchMask[lane] & busBe[lane];
    assign diffMask[lane]  = touchMask[lane] &
                             (busWdata[8*lane +: 8] != busOldData[8*lane +: 8]);
  end

  always_comb begin
    matchInfo.hitAny  = wordHit & (|touchMask);
    matchInfo.differs = |diffMask;
    matchInfo.isRead  = busRd;
    matchInfo.isWrite = busWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      breakPulse <= 1'b0;
      hitFlag    <= 1'b0;
    end else begin
      breakPulse <= strobes.fire;
      hitFlag    <= strobes.fire | (hitFlag & ~strobes.clear);
    end
  end

endmodule

// File: rtl/wp_control.sv
module wp_control
  import wp_pkg::*;
(
  input  logic       cfgEnable,
  input  logic [1:0] cfgMode,
  input  logic       clearHit,
  input  wpMatch_t   matchInfo,
  output wpStrobe_t  strobes
);

  watchMode_e mode;
  logic       modeOk;

  always_comb begin
    mode = watchMode_e'(cfgMode);
    unique case (mode)
      MODE_WRITE:  modeOk = matchInfo.isWrite;
      MODE_RDWR:   modeOk = matchInfo.isWrite | matchInfo.isRead;
      MODE_CHANGE: modeOk = matchInfo.isWrite & matchInfo.differs;
      default:     modeOk = 1'b0;
    endcase
    strobes.fire  = cfgEnable & matchInfo.hitAny & modeOk;
    strobes.clear = clearHit;
  end

endmodule

// File: rtl/wp_watch.sv
module wp_watch
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int SPAN_W = $clog2(OFF_W + 1),
  localparam int WORD_W = ADDR_W - OFF_W,
  localparam int DATA_W = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgMode,
  input  logic [SPAN_W-1:0] cfgSpan,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              clearHit,
  input  logic [WORD_W-1:0] busWordAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [BYTES-1:0]  busBe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busOldData,
  output logic              breakPulse,
  output logic              hitFlag
);

  wpMatch_t  matchInfo;
  wpStrobe_t strobes;

  wp_datapath #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgSpan    (cfgSpan),
    .cfgAddr    (cfgAddr),
    .busWordAddr(busWordAddr),
    .busRd      (busRd),
    .busWr      (busWr),
    .busBe      (busBe),
    .busWdata   (busWdata),
    .busOldData (busOldData),
    .strobes    (strobes),
    .matchInfo  (matchInfo),
    .breakPulse (breakPulse),
    .hitFlag    (hitFlag)
  );

  wp_control u_ctl (
    .cfgEnable(cfgEnable),
    .cfgMode  (cfgMode),
    .clearHit (clearHit),
    .matchInfo(matchInfo),
    .strobes  (strobes)
  );

endmodule

// File: rtl/wp_watch_chk.sv
module wp_watch_chk #(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int SPAN_W = $clog2(OFF_W + 1),
  localparam int WORD_W = ADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgEnable,
  input logic [1:0]        cfgMode,
  input logic [SPAN_W-1:0] cfgSpan,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic              clearHit,
  input logic [WORD_W-1:0] busWordAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [BYTES-1:0]  busBe,
  input logic              breakPulse,
  input logic              hitFlag
);

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(cfgEnable)) |-> !breakPulse);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(busRd) && !$past(busWr)) |-> !breakPulse);

  p_write_full_span_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && cfgEnable && cfgMode == 2'd0 && busWr && cfgSpan >= SPAN_W'(OFF_W)
          && busWordAddr == cfgAddr[ADDR_W-1:OFF_W] && (|busBe)) |-> breakPulse);

  p_reserved_mode_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cfgMode) == 2'd3) |-> !breakPulse);

  p_pulse_sets_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |-> hitFlag);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(hitFlag) && !$past(clearHit)) |-> hitFlag);

endmodule

bind wp_watch wp_watch_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgEnable  (cfgEnable),
  .cfgMode    (cfgMode),
  .cfgSpan    (cfgSpan),
  .cfgAddr    (cfgAddr),
  .clearHit   (clearHit),
  .busWordAddr(busWordAddr),
  .busRd      (busRd),
  .busWr      (busWr),
  .busBe      (busBe),
  .breakPulse (breakPulse),
  .hitFlag    (hitFlag)
);

// File: tb/tb_wp_watch.sv
`timescale 1ns/1ps
module tb_wp_watch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic [1:0]  cfgSpan = 2'd0;
  logic [31:0] cfgAddr = '0;
  logic        clearHit = 1'b0;
  logic [29:0] busWordAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busOldData = '0;
  logic        breakPulse;
  logic        hitFlag;

  int checks = 0;
  int failures = 0;
  logic expHit = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  wp_watch dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMode(cfgMode),
    .cfgSpan(cfgSpan), .cfgAddr(cfgAddr), .clearHit(clearHit),
    .busWordAddr(busWordAddr), .busRd(busRd), .busWr(busWr), .busBe(busBe),
    .busWdata(busWdata), .busOldData(busOldData),
    .breakPulse(breakPulse), .hitFlag(hitFlag)
  );

  // Reference decision, written from the requirements.
  function automatic logic refFire();
    int size;
    int base;
    logic touched = 1'b0;
    logic changed = 1'b0;
    size = (cfgSpan >= 2) ? 4 : (1 << cfgSpan);
    base = (int'(cfgAddr[1:0]) / size) * size;
    if (!cfgEnable || busWordAddr != cfgAddr[31:2]) return 1'b0;
    for (int b = 0; b < 4; b++) begin
      if (b >= base && b < base + size && busBe[b]) begin
        touched = 1'b1;
        if (busWdata[8*b +: 8] != busOldData[8*b +: 8]) changed = 1'b1;
      end
    end
    if (!touched) return 1'b0;
    case (cfgMode)
      2'd0:    return busWr;
      2'd1:    return busRd | busWr;
      2'd2:    return busWr & changed;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Inputs are set at a negedge; result is sampled at the following negedge.
  task automatic step(string tag);
    logic exp;
    exp = refFire();
    @(posedge clk);
    expHit = exp | (expHit & ~clearHit);
    @(negedge clk);
    check(tag, breakPulse, exp, "breakPulse");
    check(tag, hitFlag, expHit, "hitFlag");
  endtask

  task automatic setCfg(logic en, logic [1:0] m, logic [1:0] s, logic [31:0] a);
    cfgEnable = en; cfgMode = m; cfgSpan = s; cfgAddr = a;
  endtask

  task automatic access(logic rd, logic wr, logic [29:0] w, logic [3:0] be,
                        logic [31:0] wd, logic [31:0] od, logic clr);
    busRd = rd; busWr = wr; busWordAddr = w; busBe = be;
    busWdata = wd; busOldData = od; clearHit = clr;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    check("R11", breakPulse, 1'b0, "breakPulse in reset");
    check("R11", hitFlag, 1'b0, "hitFlag in reset");
    rstN = 1'b1;
    @(negedge clk);

    // R3: write mode, whole word at 0x100.
    setCfg(1, 2'd0, 2'd2, 32'h100);
    access(0, 1, 30'h40, 4'b0001, 32'h55, 32'h55, 0); step("R3 equal write fires");
    access(1, 0, 30'h40, 4'b1111, 0, 0, 0);           step("R3 read ignored");
    access(0, 0, 30'h40, 4'b1111, 0, 0, 0);           step("R6 single pulse");
    access(0, 0, 30'h40, 4'b1111, 0, 0, 1);           step("R7 clear");
    // R1: one-byte window on lane 3.
    setCfg(1, 2'd0, 2'd0, 32'h103);
    access(0, 1, 30'h40, 4'b0111, 1, 0, 0);           step("R1 outside lane");
    access(0, 1, 30'h40, 4'b1000, 1, 0, 0);           step("R1 lane 3");
    // R1/R2: two-byte window on lanes 2..3.
    setCfg(1, 2'd0, 2'd1, 32'h102);
    access(0, 1, 30'h40, 4'b0010, 1, 0, 1);           step("R1 lane 1 outside");
    access(0, 1, 30'h40, 4'b0100, 1, 0, 0);           step("R1 lane 2 inside");
    access(0, 1, 30'h41, 4'b1111, 1, 0, 0);           step("R2 other word");
    // R4: read/write mode.
    setCfg(1, 2'd1, 2'd2, 32'h100);
    access(1, 0, 30'h40, 4'b0100, 0, 0, 1);           step("R4 read fires");
    access(0, 1, 30'h40, 4'b1000, 0, 0, 0);           step("R4 write fires");
    // R5: change-only, window lanes 0..1.
    setCfg(1, 2'd2, 2'd1, 32'h100);
    access(0, 1, 30'h40, 4'b0011, 32'hAABB, 32'hAABB, 1);         step("R5 equal write");
    access(0, 1, 30'h40, 4'b1111, 32'h99_00AABB, 32'h11_00AABB, 0); step("R5 change outside window");
    access(0, 1, 30'h40, 4'b0001, 32'h000B, 32'h000A, 0);         step("R5 watched byte changes");
    access(1, 0, 30'h40, 4'b0011, 32'h1, 32'h2, 1);               step("R5 read ignored");
    // R10: reserved mode.
    setCfg(1, 2'd3, 2'd2, 32'h100);
    access(1, 1, 30'h40, 4'b1111, 1, 2, 0);           step("R10 reserved mode");
    // R8: disabled.
    setCfg(0, 2'd1, 2'd2, 32'h100);
    access(1, 1, 30'h40, 4'b1111, 1, 2, 0);           step("R8 disabled");
    // R9: move the window and hit it at once.
    setCfg(1, 2'd0, 2'd2, 32'h200);
    access(0, 1, 30'h80, 4'b0001, 0, 0, 0);           step("R9 new window");
    // R7: clear together with a hit keeps the flag.
    access(0, 1, 30'h80, 4'b0001, 0, 0, 1);           step("R7 clear with hit");
    access(0, 0, 30'h80, 4'b0000, 0, 0, 0);           step("R7 held");

    // Random traffic with bias toward the watched word.
    for (int i = 0; i < 3000; i++) begin
      if (i % 16 == 0)
        setCfg(($urandom % 8) != 0, 2'($urandom), 2'($urandom), {$urandom} & 32'h0000_0FFF);
      busRd = ($urandom % 3) == 0;
      busWr = ($urandom % 2) == 0;
      busWordAddr = ($urandom % 2) ? cfgAddr[31:2] : 30'($urandom % 1024);
      busBe = 4'($urandom);
      busOldData = $urandom;
      busWdata = ($urandom % 2) ? (busOldData ^ (32'hFF << (8 * ($urandom % 4))))
                                : $urandom;
      if ($urandom % 3 == 0) busWdata = busOldData;
      clearHit = ($urandom % 8) == 0;
      step("R6 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule